// File: doc/BRIEF.md
# SDRAM Command Legality Checker

This block watches the command pins of an SDRAM interface without driving anything. It tracks every bank through its life cycle: closed, opening a row, open, inside a read or write burst with or without automatic precharge, recovering from a write, precharging, refreshing, or settling after a mode-register load. Each command is judged against the state of the bank or banks it addresses and against the minimum spacing rules between commands.

A command that breaks a rule raises a one-cycle violation pulse one clock later, with a 4-bit code that names the broken rule. An offending command never changes the tracked state, so one bad command does not set off a chain of follow-on reports. Burst end is derived from the programmed burst length, and read bursts are stretched by the programmed CAS latency. The tracked state of every bank is visible on an output bus for use by a debug monitor or a higher-level checker.

Top module: `sdram_cmd_checker`

## Requirements
- R1: After reset every bank reads state 0 (closed), viol_o is 0 and err_code_o is 0.
- R2: Commands are decoded on the rising edge from {cs_ni, ras_ni, cas_ni, we_ni}. cs_ni high is deselect. With cs_ni low, ras/cas/we = 000 mode load, 001 refresh, 010 precharge (a10_i high means all banks), 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. For read and write, a10_i high selects auto-precharge. A violating command raises viol_o for exactly the next cycle, with its code on err_code_o. Otherwise both outputs are 0.
- R3: A mode load or a refresh while any bank is not closed gives code 1. A legal refresh puts every bank in state 9 for T_RC-1 cycles. A legal mode load puts every bank in state 10 for T_MRD-1 cycles.
- R4: A read or write to a closed bank gives code 2. An activate to a bank in state 2, 3, 4 or 7 gives code 3.
- R5: While a bank is in state 5 or 6, any precharge, activate, read or write to it, and any burst stop, gives code 4. State 5 ends in state 8.
- R6: A legal activate puts the bank in state 1. While it is there, any activate, read, write or precharge to it gives code 4'd5. The bank reaches state 2 exactly T_RCD cycles after the activate.
- R7: While a bank is in state 8, an activate, read or write to it gives code 6. The same holds in states 9 and 10, where a precharge or a burst stop also gives code 6. An explicit precharge returns the bank to state 0 T_RP cycles after the command.
- R8: An activate less than T_RRD cycles after the previous accepted activate gives code 7.
- R9: A precharge to a bank less than T_RAS cycles after its activate gives code 8.
- R10: A write puts the bank in state 4 for BL cycles, then in state 7 for T_WR cycles, then in state 2. A precharge in state 7 gives code 9.
- R11: A read holds state 3 for BL+CL-1 cycles, then the bank returns to state 2. A read or write during a burst restarts the access. A burst stop returns the bank to state 2 at once. Burst length is 2^burst_len_i and CL is cas_lat_i.
- R12: A violating command leaves every bank state unchanged. Timed states still advance.
- R13: bank_state_o holds 4 bits per bank, bank b at bits [4b+3:4b]. The codes are 0 closed, 1 opening, 2 open, 3 read, 4 write, 5 read with auto-precharge, 6 write with auto-precharge, 7 write recovery, 8 precharging, 9 refreshing and 10 mode load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| bank_i | input | 2 | Bank address |
| a10_i | input | 1 | All-bank / auto-precharge select |
| burst_len_i | input | 2 | Log2 of the programmed burst length |
| cas_lat_i | input | 2 | Programmed CAS latency (2 or 3) |
| viol_o | output | 1 | One-cycle violation pulse |
| err_code_o | output | 4 | Broken-rule code, valid with viol_o |
| bank_state_o | output | 16 | Tracked state of each bank |

## Verification
Embedded properties check, on every cycle, several structural rules. A closed bank can only go to opening, refreshing or mode-load. A read burst with auto-precharge can only end in precharging. An untimed state holds whenever a command is rejected. A refresh always covers every bank together. Two accepted activates are never closer than the row-to-row delay. The exact error code chosen for each illegal command, the cycle counts of opening, precharge, refresh, burst and recovery windows, and the effect of CAS latency and burst length on burst end only show up in the bench's timed command sequences. In those sequences every cycle's output is compared with a predicted code.

// File: rtl/sdr_chk_pkg.sv
package sdr_chk_pkg;

  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_OPENING   = 4'd1,
    ST_OPEN      = 4'd2,
    ST_READ      = 4'd3,
    ST_WRITE     = 4'd4,
    ST_READ_AP   = 4'd5,
    ST_WRITE_AP  = 4'd6,
    ST_WR_RECOV  = 4'd7,
    ST_PRECHG    = 4'd8,
    ST_REFRESH   = 4'd9,
    ST_MODE_LOAD = 4'd10
  } bank_st_e;

  typedef enum logic [3:0] {
    CMD_NOP, CMD_DESEL, CMD_MODE, CMD_REF, CMD_PRE,
    CMD_ACT, CMD_WR, CMD_RD, CMD_BST
  } cmd_e;

  localparam logic [3:0] E_NONE      = 4'd0;
  localparam logic [3:0] E_NOT_IDLE  = 4'd1;
  localparam logic [3:0] E_NOT_OPEN  = 4'd2;
  localparam logic [3:0] E_ROW_OPEN  = 4'd3;
  localparam logic [3:0] E_AP_LOCK   = 4'd4;
  localparam logic [3:0] E_OPENING   = 4'd5;
  localparam logic [3:0] E_BUSY      = 4'd6;
  localparam logic [3:0] E_TRRD      = 4'd7;
  localparam logic [3:0] E_TRAS      = 4'd8;
  localparam logic [3:0] E_RECOV     = 4'd9;

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_chk_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_ni) cmd_o = CMD_DESEL;
    else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b000:  cmd_o = CMD_MODE;
        3'b001:  cmd_o = CMD_REF;
        3'b010:  cmd_o = CMD_PRE;
        3'b011:  cmd_o = CMD_ACT;
        3'b100:  cmd_o = CMD_WR;
        3'b101:  cmd_o = CMD_RD;
        3'b110:  cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
  import sdr_chk_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 6,
  parameter int T_RC  = 8,
  parameter int T_MRD = 2,
  parameter int T_WR  = 1,
  parameter int TMR_W = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cmd_e       cmd_i,
  input  logic       hit_i,
  input  logic       a10_i,
  input  logic [1:0] burst_len_i,
  input  logic [1:0] cas_lat_i,
  input  logic       commit_i,
  output logic [3:0] err_o,
  output bank_st_e   state_o
);
  localparam int RAS_W = $clog2(T_RAS + 1);

  bank_st_e           state_q, state_d;
  logic [TMR_W-1:0]   tmr_q, tmr_d;
  logic [RAS_W-1:0]   ras_cnt_q;
  logic [TMR_W-1:0]   bl, rd_len;
  logic               timed, col_cmd, acc_cmd;

  assign bl      = TMR_W'(1) << burst_len_i;
  assign rd_len  = bl + TMR_W'(cas_lat_i) - TMR_W'(1);
  assign timed   = !(state_q inside {ST_IDLE, ST_OPEN});
  assign col_cmd = cmd_i inside {CMD_RD, CMD_WR};
  assign acc_cmd = cmd_i inside {CMD_RD, CMD_WR, CMD_ACT, CMD_PRE, CMD_BST};
  assign state_o = state_q;

  always_comb begin
    err_o = E_NONE;
    if (hit_i && acc_cmd) begin
      unique case (state_q)
        ST_IDLE:    if (col_cmd) err_o = E_NOT_OPEN;
        ST_OPENING: if (cmd_i != CMD_BST) err_o = E_OPENING;
        ST_OPEN, ST_READ, ST_WRITE: begin
          if (cmd_i == CMD_ACT) err_o = E_ROW_OPEN;
          else if (cmd_i == CMD_PRE && ras_cnt_q < RAS_W'(T_RAS)) err_o = E_TRAS;
        end
        ST_WR_RECOV: begin
          if (cmd_i == CMD_ACT) err_o = E_ROW_OPEN;
          else if (cmd_i == CMD_PRE) err_o = E_RECOV;
        end
        ST_READ_AP, ST_WRITE_AP: err_o = E_AP_LOCK;
        ST_PRECHG:  if (col_cmd || cmd_i == CMD_ACT) err_o = E_BUSY;
        default:    err_o = E_BUSY;
      endcase
    end
  end

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    if (timed) begin
      if (tmr_q == TMR_W'(1)) begin
        unique case (state_q)
          ST_WRITE:                begin state_d = ST_WR_RECOV; tmr_d = TMR_W'(T_WR); end
          ST_READ_AP, ST_WRITE_AP: begin state_d = ST_PRECHG;   tmr_d = TMR_W'(T_RP); end
          ST_OPENING, ST_READ, ST_WR_RECOV: state_d = ST_OPEN;
          default:                 state_d = ST_IDLE;
        endcase
      end else tmr_d = tmr_q - TMR_W'(1);
    end
    if (commit_i) begin
      unique case (cmd_i)
        CMD_ACT: if (hit_i) begin state_d = ST_OPENING; tmr_d = TMR_W'(T_RCD - 1); end
        CMD_RD:  if (hit_i) begin state_d = a10_i ? ST_READ_AP : ST_READ; tmr_d = rd_len; end
        CMD_WR:  if (hit_i) begin
          state_d = a10_i ? ST_WRITE_AP : ST_WRITE;
          tmr_d   = a10_i ? bl + TMR_W'(T_WR) : bl;
        end
        CMD_PRE: if (hit_i && state_q inside {ST_OPEN, ST_READ, ST_WRITE}) begin
          state_d = ST_PRECHG; tmr_d = TMR_W'(T_RP - 1);
        end
        CMD_BST: if (state_q inside {ST_READ, ST_WRITE}) state_d = ST_OPEN;
        CMD_REF:  begin state_d = ST_REFRESH;   tmr_d = TMR_W'(T_RC - 1);  end
        CMD_MODE: begin state_d = ST_MODE_LOAD; tmr_d = TMR_W'(T_MRD - 1); end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tmr_q     <= '0;
      ras_cnt_q <= RAS_W'(T_RAS);
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      if (commit_i && hit_i && cmd_i == CMD_ACT) ras_cnt_q <= RAS_W'(1);
      else if (ras_cnt_q < RAS_W'(T_RAS))        ras_cnt_q <= ras_cnt_q + RAS_W'(1);
    end
  end

  assert_idle_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> (state_q inside {ST_IDLE, ST_OPENING, ST_REFRESH, ST_MODE_LOAD}));

  assert_ap_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ_AP) |=> (state_q inside {ST_READ_AP, ST_PRECHG}));

  assert_reject_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !timed) |=> (state_q == $past(state_q)));

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdr_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 6,
  parameter int T_RC  = 8,
  parameter int T_RRD = 2,
  parameter int T_MRD = 2,
  parameter int T_WR  = 1,
  parameter int TMR_W = 5,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int RRD_W  = $clog2(T_RRD + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   ras_ni,
  input  logic                   cas_ni,
  input  logic                   we_ni,
  input  logic [BANK_W-1:0]      bank_i,
  input  logic                   a10_i,
  input  logic [1:0]             burst_len_i,
  input  logic [1:0]             cas_lat_i,
  output logic                   viol_o,
  output logic [3:0]             err_code_o,
  output logic [NUM_BANKS*4-1:0] bank_state_o
);
  cmd_e             cmd;
  logic [3:0]       err;
  logic             commit, all_idle;
  logic [RRD_W-1:0] rrd_cnt_q;
  logic [3:0]       bank_err [NUM_BANKS];
  bank_st_e         bank_st  [NUM_BANKS];
  logic [NUM_BANKS-1:0] idle_vec, hit_vec;

  sdr_cmd_decode u_dec (
    .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .cmd_o(cmd)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign hit_vec[b] = (bank_i == BANK_W'(b)) || (cmd == CMD_PRE && a10_i) || (cmd == CMD_BST);
    sdr_bank_track #(
      .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
      .T_MRD(T_MRD), .T_WR(T_WR), .TMR_W(TMR_W)
    ) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd), .hit_i(hit_vec[b]),
      .a10_i(a10_i), .burst_len_i(burst_len_i), .cas_lat_i(cas_lat_i),
      .commit_i(commit), .err_o(bank_err[b]), .state_o(bank_st[b])
    );
    assign idle_vec[b]          = (bank_st[b] == ST_IDLE);
    assign bank_state_o[b*4 +: 4] = bank_st[b];
  end

  assign all_idle = &idle_vec;

  // lowest-numbered bank wins, then bus-wide rules
  always_comb begin
    err = E_NONE;
    for (int b = NUM_BANKS - 1; b >= 0; b--)
      if (bank_err[b] != E_NONE) err = bank_err[b];
    if (err == E_NONE) begin
      if ((cmd == CMD_MODE || cmd == CMD_REF) && !all_idle) err = E_NOT_IDLE;
      else if (cmd == CMD_ACT && rrd_cnt_q < RRD_W'(T_RRD)) err = E_TRRD;
    end
  end

  assign commit = (err == E_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rrd_cnt_q  <= RRD_W'(T_RRD);
      viol_o     <= 1'b0;
      err_code_o <= E_NONE;
    end else begin
      viol_o     <= !commit;
      err_code_o <= err;
      if (commit && cmd == CMD_ACT)        rrd_cnt_q <= RRD_W'(1);
      else if (rrd_cnt_q < RRD_W'(T_RRD))  rrd_cnt_q <= rrd_cnt_q + RRD_W'(1);
    end
  end

  assert_refresh_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_st[0] == ST_REFRESH) |-> (bank_st[NUM_BANKS-1] == ST_REFRESH));

  assert_code_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (err_code_o != E_NONE));

  if (T_RRD > 1) begin : g_rrd_chk
    assert_act_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit && cmd == CMD_ACT) |=> !(commit && cmd == CMD_ACT));
  end

endmodule

// File: tb/tb_sdram_cmd_checker.sv
`timescale 1ns/1ps
module tb_sdram_cmd_checker;
  localparam logic [3:0] P_NOP = 4'b0111, P_MODE = 4'b0000, P_REF = 4'b0001,
                         P_PRE = 4'b0010, P_ACT = 4'b0011, P_WR = 4'b0100,
                         P_RD  = 4'b0101, P_BST = 4'b0110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] bank = '0, bl_code = 2'd2, cl = 2'd2;
  logic a10 = 1'b0;
  logic viol;
  logic [3:0] code;
  logic [15:0] states;

  int checks = 0, fails = 0;
  bit done = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  sdram_cmd_checker dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .bank_i(bank), .a10_i(a10), .burst_len_i(bl_code),
    .cas_lat_i(cl), .viol_o(viol), .err_code_o(code), .bank_state_o(states)
  );

  // monitor: one expected item per driven cycle
  initial forever begin
    @(posedge clk); #1;
    if (exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (code !== 4'(e) || viol !== (e != 0)) begin
        fails++;
        $display("FAIL %s: viol=%0b code=%0d expected viol=%0b code=%0d", t, viol, code, (e != 0), e);
      end
    end
  end

  task automatic issue(input logic [3:0] p, input int b, input bit ap, input int e, input string t);
    {cs_n, ras_n, cas_n, we_n} = p;
    bank = 2'(b);
    a10  = ap;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) issue(P_NOP, 0, 0, 0, "R2_nop");
  endtask

  task automatic chk_state(input int b, input int e, input string t);
    checks++;
    if (states[b*4 +: 4] !== 4'(e)) begin
      fails++;
      $display("FAIL %s: bank%0d state=%0d expected %0d", t, b, states[b*4 +: 4], e);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (viol !== 1'b0 || code !== 4'd0) begin
      fails++;
      $display("FAIL R1: viol=%0b code=%0d expected viol=0 code=0", viol, code);
    end
    for (int b = 0; b < 4; b++) chk_state(b, 0, "R1_R13_reset");
    rst_n = 1'b1;
    @(negedge clk);

    // basic rules on bank 0
    issue(P_RD,  0, 0, 2, "R4_rd_idle");
    chk_state(0, 0, "R12_rejected_rd");
    issue(P_ACT, 0, 0, 0, "R6_act");
    issue(P_ACT, 1, 0, 7, "R8_trrd");
    issue(P_RD,  0, 0, 5, "R6_rd_opening");
    chk_state(0, 2, "R6_open_after_trcd");
    chk_state(1, 0, "R12_rejected_act");
    issue(P_ACT, 0, 0, 3, "R4_act_open");
    issue(P_PRE, 0, 0, 8, "R9_tras");
    issue(P_RD,  0, 0, 0, "R11_rd");
    chk_state(0, 3, "R11_read_state");
    issue(P_BST, 0, 0, 0, "R11_bst");
    chk_state(0, 2, "R11_bst_open");
    issue(P_WR,  0, 0, 0, "R10_wr");
    nop(4);
    chk_state(0, 7, "R10_recovery");
    issue(P_PRE, 0, 0, 9, "R10_pre_recov");
    chk_state(0, 2, "R10_open_after_recov");
    issue(P_PRE, 0, 0, 0, "R7_pre");
    issue(P_ACT, 0, 0, 6, "R7_act_prechg");
    nop(1);
    chk_state(0, 0, "R7_idle_after_trp");

    // auto-precharge lock on bank 2
    issue(P_ACT, 2, 0, 0, "R5_act");
    nop(2);
    issue(P_RD,  2, 1, 0, "R5_rd_ap");
    issue(P_PRE, 2, 0, 4, "R5_pre_lock");
    issue(P_ACT, 2, 0, 4, "R5_act_lock");
    issue(P_WR,  2, 0, 4, "R5_wr_lock");
    issue(P_BST, 0, 0, 4, "R5_bst_lock");
    nop(1);
    chk_state(2, 8, "R5_to_prechg");
    nop(3);
    chk_state(2, 0, "R5_idle");

    // bus-wide commands
    issue(P_ACT, 3, 0, 0, "R3_act");
    issue(P_REF, 0, 0, 1, "R3_ref_busy");
    chk_state(3, 1, "R12_ref_rejected");
    nop(5);
    issue(P_PRE, 0, 1, 0, "R7_pre_all");
    nop(2);
    chk_state(3, 0, "R7_pre_all_idle");
    issue(P_REF, 0, 0, 0, "R3_ref");
    for (int b = 0; b < 4; b++) chk_state(b, 9, "R3_refreshing");
    issue(P_MODE, 0, 0, 1, "R3_mode_busy");
    issue(P_ACT, 0, 0, 6, "R7_act_refresh");
    nop(5);
    chk_state(0, 0, "R3_idle_after_trc");
    issue(P_MODE, 0, 0, 0, "R3_mode");
    issue(P_RD,  0, 0, 6, "R7_rd_mode_load");
    chk_state(0, 0, "R3_idle_after_mode");

    // CAS latency stretches the read burst, restart by write
    cl = 2'd3;
    issue(P_ACT, 1, 0, 0, "R11_act");
    nop(2);
    issue(P_RD,  1, 0, 0, "R11_rd_cl3");
    nop(5);
    chk_state(1, 3, "R11_read_cl3_last");
    nop(1);
    chk_state(1, 2, "R11_read_cl3_done");
    issue(P_RD,  1, 0, 0, "R11_rd2");
    issue(P_WR,  1, 0, 0, "R11_restart");
    chk_state(1, 4, "R11_write_restart");
    issue(P_NOP, 0, 0, 0, "R2_no_pulse");
    nop(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule